// File: doc/BRIEF.md
# Four-Class Parallel ALU

A purely combinational integer ALU for a single-issue datapath. Four operation groups (bitwise logic, add/subtract, set-on-less-than and barrel shift) all evaluate the same operands at once. A 2-bit class field in the opcode then picks one of the four results. A 2-bit sub-operation field chooses the function inside each group.

The set-on-less-than results come from the adder, not from a comparator of their own. For these codes the adder computes A minus B. The compare logic reads that difference's sign bit, the sign bits of both operands and the adder carry. The carry, overflow and zero flags are driven from the same adder. The block holds no state: the result and flags follow the inputs within the same cycle. The parent pipeline registers them. Because nothing streams through the block, it has no valid/ready handshake.

Top module: `quad_class_alu`

## Requirements
- R1: `opcode[3:2]` picks the result group: 00 gives logic, 01 gives add/subtract, 10 gives compare, 11 gives shift.
- R2: In the logic group, `opcode[1:0]` picks 00 AND, 01 OR, 10 XOR, 11 NOR.
- R3: In the add/subtract group, `opcode[1:0]` picks 00 signed add, 01 unsigned add, 10 signed subtract, 11 unsigned subtract. All four wrap modulo 2^W.
- R4: Compare code 10 is signed less-than. When the operand signs differ, it returns 1 exactly when `opa` is negative. When the signs match, it returns the sign bit of `opa - opb`.
- R5: Compare code 11 is unsigned less-than and returns the inverse of the subtract carry. Compare codes 00 and 01 return zero. A compare result occupies bit 0 only, and every higher bit is 0.
- R6: `overflow` can rise only for opcodes 0100 and 0110. It is 1 when the two operand signs fed to the adder (after `opb` is inverted for a subtract) are equal and the sum's sign differs from them.
- R7: In every group, the adder adds when `opcode[1]` is 0. When `opcode[1]` is 1 it computes `opa + ~opb + 1`. `carry_out` is the adder's carry out of the top bit. `zero` is 1 exactly when the adder sum is all zeros.
- R8: In the shift group, the shift distance is `shamt`. Code 00 shifts `opa` left and fills with zeros. Codes 01 and 10 shift right and fill with zeros. Code 11 shifts right and fills with copies of `opa`'s sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W (32) | First operand; the only shifted operand |
| opb | input | W (32) | Second operand |
| shamt | input | $clog2(W) (5) | Shift distance |
| opcode | input | 4 | Group in [3:2], function in [1:0] |
| result | output | W (32) | Selected result |
| carry_out | output | 1 | Adder carry out of the top bit |
| overflow | output | 1 | Signed overflow for signed add and signed subtract |
| zero | output | 1 | Adder sum is all zeros |

## Verification
Signed less-than and signed-subtract overflow are two functions that can both occur on the same operands. When `opa` and `opb` have opposite signs and large magnitudes, `opa - opb` wraps, and its sign bit then gives the wrong ordering. The operand set includes the pairs 0x7FFFFFFF/0x80000000 and 0x80000001/0x7FFFFFFF. The bench applies each pair under the signed-subtract code, where `overflow` must be 1. It applies the same pair under the signed-compare code, where bit 0 must still match true signed ordering. The expected values are computed in the bench from 33-bit arithmetic and signed comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    CLS_LOGIC = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_CMP   = 2'b10,
    CLS_SHIFT = 2'b11
  } alu_class_e;

  localparam logic [1:0] SUB_SLT  = 2'b10;
  localparam logic [1:0] SUB_SLTU = 2'b11;
  localparam logic [1:0] SUB_SLL  = 2'b00;
  localparam logic [1:0] SUB_SRA  = 2'b11;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sub)
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

  always_comb begin
    if (sub == 2'b11) a_r2_nor_clear: assert ((y & a) == '0);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf_raw,
  output logic         zero,
  output logic         a_sign,
  output logic         b_sign
);
  logic         do_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign do_sub  = sub[1];
  assign b_eff   = do_sub ? ~b : b;
  assign wide    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
  assign sum     = wide[W-1:0];
  assign cout    = wide[W];
  assign zero    = (sum == '0);
  assign a_sign  = a[W-1];
  assign b_sign  = b[W-1];
  assign ovf_raw = ~sub[0] & (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);

  always_comb begin
    if (do_sub) a_r7_sub_value: assert (sum == a - b);
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int W = 32
) (
  input  logic [1:0]   sub,
  input  logic         a_sign,
  input  logic         b_sign,
  input  logic         diff_sign,
  input  logic         cout,
  output logic [W-1:0] y
);
  import alu_pkg::*;
  logic lt;

  always_comb begin
    lt = 1'b0;
    if (sub == SUB_SLT) lt = (a_sign != b_sign) ? a_sign : diff_sign;
    else if (sub == SUB_SLTU) lt = ~cout;
  end

  assign y = {{(W-1){1'b0}}, lt};

  always_comb begin
    if (!sub[1]) a_r5_low_codes_zero: assert (y == '0);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] shamt,
  input  logic [1:0]     sub,
  output logic [W-1:0]   y
);
  import alu_pkg::*;
  logic         fill;
  logic [W-1:0] lstage [0:SHW];
  logic [W-1:0] rstage [0:SHW];

  assign fill      = (sub == SUB_SRA) ? a[W-1] : 1'b0;
  assign lstage[0] = a;
  assign rstage[0] = a;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign lstage[k+1] = shamt[k] ? {lstage[k][W-1-STEP:0], {STEP{1'b0}}} : lstage[k];
    assign rstage[k+1] = shamt[k] ? {{STEP{fill}}, rstage[k][W-1:STEP]} : rstage[k];
  end

  assign y = (sub == SUB_SLL) ? lstage[SHW] : rstage[SHW];

  always_comb begin
    if (sub == SUB_SLL) a_r8_sll: assert (y == (a << shamt));
    if (sub == SUB_SRA) a_r8_sra: assert (y == W'($signed(a) >>> shamt));
  end
endmodule

// File: rtl/quad_class_alu.sv
module quad_class_alu #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [SHW-1:0] shamt,
  input  logic [3:0]     opcode,
  output logic [W-1:0]   result,
  output logic           carry_out,
  output logic           overflow,
  output logic           zero
);
  import alu_pkg::*;

  alu_class_e   cls;
  logic [1:0]   sub;
  logic [W-1:0] logic_y, arith_y, cmp_y, shift_y;
  logic         ovf_raw, a_sign, b_sign;

  assign cls = alu_class_e'(opcode[3:2]);
  assign sub = opcode[1:0];

  alu_logic_unit #(.W(W)) u_logic (.a(opa), .b(opb), .sub(sub), .y(logic_y));

  alu_addsub #(.W(W)) u_arith (
    .a(opa), .b(opb), .sub(sub), .sum(arith_y), .cout(carry_out),
    .ovf_raw(ovf_raw), .zero(zero), .a_sign(a_sign), .b_sign(b_sign)
  );

  alu_compare #(.W(W)) u_cmp (
    .sub(sub), .a_sign(a_sign), .b_sign(b_sign), .diff_sign(arith_y[W-1]),
    .cout(carry_out), .y(cmp_y)
  );

  alu_shifter #(.W(W)) u_shift (.a(opa), .shamt(shamt), .sub(sub), .y(shift_y));

  assign overflow = (cls == CLS_ARITH) & ovf_raw;

  always_comb begin
    unique case (cls)
      CLS_LOGIC: result = logic_y;
      CLS_ARITH: result = arith_y;
      CLS_CMP:   result = cmp_y;
      default:   result = shift_y;
    endcase
  end

  always_comb begin
    if (cls != CLS_ARITH) a_r6_no_overflow: assert (!overflow);
    if (cls == CLS_CMP && sub == SUB_SLT)
      a_r4_slt: assert (result == {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))});
    if (cls == CLS_CMP && sub == SUB_SLTU)
      a_r5_sltu: assert (result == {{(W-1){1'b0}}, (opa < opb)});
    if (overflow && sub == 2'b00) a_r6_add_signs: assert (opa[W-1] == opb[W-1]);
    if (cls == CLS_LOGIC && sub == 2'b00) a_r1_and_sel: assert (result == (opa & opb));
  end
endmodule

// File: tb/quad_class_alu_bench.sv
module quad_class_alu_bench;
  localparam int W = 32;
  localparam int SHW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]   opa = '0, opb = '0;
  logic [SHW-1:0] shamt = '0;
  logic [3:0]     opcode = '0;
  logic [W-1:0]   result;
  logic           carry_out, overflow, zero;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  quad_class_alu #(.W(W)) u_quad_class_alu (
    .opa(opa), .opb(opb), .shamt(shamt), .opcode(opcode),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  function automatic logic [W-1:0] pattern(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h8000_0001;
      6: return 32'h1234_5678;
      7: return 32'hFEDC_BA98;
      8: return 32'h5555_5555;
      default: return 32'hAAAA_AAAA;
    endcase
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op[3:2])
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return (op[1:0] == 2'b10) ? "R4" : "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%b a=%h b=%h sh=%0d got=%h exp=%h",
               req, opcode, opa, opb, shamt, got, exp);
    end
  endtask

  task automatic run_vec(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [SHW-1:0] sh);
    logic [W:0]   wide;
    logic [W-1:0] bx, exp_res;
    logic         exp_ovf, do_sub;
    @(posedge clk);
    opcode = op; opa = a; opb = b; shamt = sh;
    do_sub = op[1];
    bx   = do_sub ? ~b : b;
    wide = {1'b0, a} + {1'b0, bx} + (do_sub ? 33'd1 : 33'd0);
    exp_ovf = (op == 4'b0100 || op == 4'b0110) &&
              (a[W-1] == bx[W-1]) && (wide[W-1] != a[W-1]);
    case (op[3:2])
      2'b00: case (op[1:0])
               2'b00: exp_res = a & b;
               2'b01: exp_res = a | b;
               2'b10: exp_res = a ^ b;
               default: exp_res = ~(a | b);
             endcase
      2'b01: exp_res = do_sub ? a - b : a + b;
      2'b10: case (op[1:0])
               2'b10: exp_res = {31'd0, ($signed(a) < $signed(b))};
               2'b11: exp_res = {31'd0, (a < b)};
               default: exp_res = '0;
             endcase
      default: case (op[1:0])
                 2'b00: exp_res = a << sh;
                 2'b11: exp_res = W'($signed(a) >>> sh);
                 default: exp_res = a >> sh;
               endcase
    endcase
    @(negedge clk);
    check({"R1/", tag(op)}, result, exp_res);
    check("R7 carry", {31'd0, carry_out}, {31'd0, wide[W]});
    check("R7 zero", {31'd0, zero}, {31'd0, (wide[W-1:0] == '0)});
    check("R6 overflow", {31'd0, overflow}, {31'd0, exp_ovf});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 idle state: AND of zeros, adder sum zero
    check("R1 idle result", result, '0);
    check("R7 idle zero", {31'd0, zero}, 32'd1);
    check("R7 idle carry", {31'd0, carry_out}, 32'd0);
    check("R6 idle overflow", {31'd0, overflow}, 32'd0);
    rst = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_vec(4'(op), pattern(i), pattern(j), 5'((i * 7 + j * 3) % 32));
    // R8: every shift distance under every shift code
    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 4; c++) begin
        run_vec({2'b11, 2'(c)}, 32'h8765_4321, 32'h0, 5'(s));
        run_vec({2'b11, 2'(c)}, 32'h4321_8765, 32'h0, 5'(s));
      end
    // R4 with R6: wrapped difference under signed compare and signed subtract
    run_vec(4'b0110, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    run_vec(4'b1010, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    run_vec(4'b0110, 32'h8000_0001, 32'h7FFF_FFFF, 5'd0);
    run_vec(4'b1010, 32'h8000_0001, 32'h7FFF_FFFF, 5'd0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    summary();
  end
endmodule